// File: doc/BRIEF.md
# Multi-Operator Gradient Magnitude Pipeline

This block turns a stream of 3x3 grayscale pixel windows into edge-strength values. Every clock it may accept one window, and it computes horizontal and vertical first-derivative gradients for three operators side by side: a 3x3 weighted-centre operator (Sobel), a 3x3 flat-weight operator (Prewitt) and a 2x2 diagonal operator (Roberts). Each operator's magnitude is approximated as the sum of the absolute values of its two gradients. A 3-bit mode code that travels with each window chooses which operators produce a result for that window.

The datapath is a four-stage pipeline with no stalls: window capture, gradient computation, absolute value and magnitude sum. Each operator has its own lane with its own output valid. An upstream line-buffer or frame memory supplies the windows, and a downstream stage consumes one magnitude per enabled operator per clock. Thresholding and edge direction are left to later stages.

Top module: `grad_mag_pipe`

## Requirements
- R1: Lane 0 (mag_o bits [MAG_W-1:0]) gives |Gx|+|Gy| with Gx = (D6+2·D7+D8) − (D0+2·D1+D2) and Gy = (D0+2·D3+D6) − (D2+2·D5+D8). Pixel Dk sits at win_i bits [8k+7:8k]. D0..D8 are row-major and D4 is the centre.
- R2: Lane 1 (mag_o bits [2·MAG_W-1:MAG_W]) gives |Gx|+|Gy| with Gx = (D0+D1+D2) − (D6+D7+D8) and Gy = (D2+D5+D8) − (D0+D3+D6).
- R3: Lane 2 (mag_o bits [3·MAG_W-1:2·MAG_W]) gives |Gx|+|Gy| with Gx = D4 − D8 and Gy = D5 − D7.
- R4: For a valid window, mode_i sets the lane-enable mask mag_vld_o (bit 0 Sobel, bit 1 Prewitt, bit 2 Roberts) as follows: 000→000, 001→001, 010→010, 011→100, 100→011, 101→110, 110→101, 111→111.
- R5: A window sampled at clock edge N yields its results and valids right after edge N+3, which is four edges in all. Back-to-back windows yield one result per enabled lane on every clock with no stalls.
- R6: A window presented with win_vld_i low raises no bit of mag_vld_o.
- R7: A synchronous active-high rst clears every valid in the pipeline. mag_vld_o is 0 after any edge with rst high, and windows that were in flight at that edge never emerge.
- R8: Negative gradients add their absolute value to the magnitude. Results reach the full worst case (6·255 = 1530 for lane 0) without saturation or wrap in the 11-bit output.
- R9: mode_i is sampled together with each window. A mode change between consecutive windows affects only the windows that carry the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_i | input | 9·PIX_W (72) | 3x3 window; Dk at bits [PIX_W·k+PIX_W-1 : PIX_W·k] |
| win_vld_i | input | 1 | Window valid |
| mode_i | input | 3 | Operator-combination code, sampled with the window |
| mag_o | output | 3·MAG_W (33) | Magnitudes: lane 0 Sobel, lane 1 Prewitt, lane 2 Roberts |
| mag_vld_o | output | 3 | Per-lane result valid |

## Verification
The bench builds the block with the default PIX_W = 8, so gradients are 12-bit and magnitudes 11-bit. At this width the whole mode code space can be crossed with every single-pixel extreme, the all-zero and all-full windows and the worst-case Sobel corner, and each lane's arithmetic is recomputed in integers. Random windows with a random mode on every clock and gaps in the valid check that the enable follows each window. A reset asserted mid-stream checks that windows in flight are dropped.

// File: rtl/grad_pkg.sv
`timescale 1ns/1ps
package grad_pkg;
   localparam int LANES      = 3;
   localparam int OP_SOBEL   = 0;
   localparam int OP_PREWITT = 1;
   localparam int OP_ROBERTS = 2;
   localparam int WIN_PIX    = 9;

   // operator-combination code to lane mask (bit0 Sobel, bit1 Prewitt, bit2 Roberts)
   function automatic logic [LANES-1:0] mode_to_mask(input logic [2:0] code);
      logic [LANES-1:0] m;
      case (code)
         3'b001:  m = 3'b001;
         3'b010:  m = 3'b010;
         3'b011:  m = 3'b100;
         3'b100:  m = 3'b011;
         3'b101:  m = 3'b110;
         3'b110:  m = 3'b101;
         3'b111:  m = 3'b111;
         default: m = 3'b000;
      endcase
      return m;
   endfunction
endpackage

// File: rtl/grad_kernel.sv
`timescale 1ns/1ps
module grad_kernel #(
   parameter int PIX_W = 8,
   parameter int OP    = 0,
   localparam int GRAD_W = PIX_W + 4
) (
   input  logic [9*PIX_W-1:0]        win,
   output logic signed [GRAD_W-1:0]  gx,
   output logic signed [GRAD_W-1:0]  gy
);
   import grad_pkg::*;

   logic signed [GRAD_W-1:0] px [WIN_PIX];

   always_comb begin
      for (int k = 0; k < WIN_PIX; k++)
         px[k] = $signed({{(GRAD_W-PIX_W){1'b0}}, win[k*PIX_W +: PIX_W]});
   end

   generate
      if (OP == OP_SOBEL) begin : g_sobel
         always_comb begin
            gx = (px[6] + px[7] + px[7] + px[8]) - (px[0] + px[1] + px[1] + px[2]);
            gy = (px[0] + px[3] + px[3] + px[6]) - (px[2] + px[5] + px[5] + px[8]);
         end
      end else if (OP == OP_PREWITT) begin : g_prewitt
         always_comb begin
            gx = (px[0] + px[1] + px[2]) - (px[6] + px[7] + px[8]);
            gy = (px[2] + px[5] + px[8]) - (px[0] + px[3] + px[6]);
         end
      end else begin : g_roberts
         always_comb begin
            gx = px[4] - px[8];
            gy = px[5] - px[7];
         end
      end
   endgenerate
endmodule

// File: rtl/grad_lane.sv
`timescale 1ns/1ps
module grad_lane #(
   parameter int PIX_W = 8,
   parameter int OP    = 0,
   localparam int GRAD_W = PIX_W + 4,
   localparam int MAG_W  = PIX_W + 3
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [9*PIX_W-1:0]   win,
   input  logic                 vld_i,
   output logic [MAG_W-1:0]     mag_o,
   output logic                 vld_o
);
   logic signed [GRAD_W-1:0] gx_c, gy_c, gx_q, gy_q;
   logic [MAG_W-1:0]         ax_c, ay_c, ax_q, ay_q, mag_q;
   logic                     v_grad, v_abs, v_mag;

   grad_kernel #(.PIX_W(PIX_W), .OP(OP)) u_kernel (
      .win (win),
      .gx  (gx_c),
      .gy  (gy_c)
   );

   // magnitude never exceeds MAG_W bits, so the sign bit selects negation
   always_comb begin
      ax_c = gx_q[GRAD_W-1] ? (~gx_q[MAG_W-1:0] + MAG_W'(1)) : gx_q[MAG_W-1:0];
      ay_c = gy_q[GRAD_W-1] ? (~gy_q[MAG_W-1:0] + MAG_W'(1)) : gy_q[MAG_W-1:0];
   end

   always_ff @(posedge clk) begin
      gx_q  <= gx_c;
      gy_q  <= gy_c;
      ax_q  <= ax_c;
      ay_q  <= ay_c;
      mag_q <= ax_q + ay_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         v_grad <= 1'b0;
         v_abs  <= 1'b0;
         v_mag  <= 1'b0;
      end else begin
         v_grad <= vld_i;
         v_abs  <= v_grad;
         v_mag  <= v_abs;
      end
   end

   assign mag_o = mag_q;
   assign vld_o = v_mag;
endmodule

// File: rtl/grad_mag_pipe.sv
`timescale 1ns/1ps
module grad_mag_pipe #(
   parameter int PIX_W = 8,
   localparam int MAG_W = PIX_W + 3,
   localparam int NL    = 3
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [9*PIX_W-1:0]   win_i,
   input  logic                 win_vld_i,
   input  logic [2:0]           mode_i,
   output logic [NL*MAG_W-1:0]  mag_o,
   output logic [NL-1:0]        mag_vld_o
);
   import grad_pkg::*;

   if (PIX_W < 2 || PIX_W > 16) begin : g_bad_pix_w
      $error("grad_mag_pipe: PIX_W must lie in 2..16");
   end
   if (NL != LANES) begin : g_bad_lanes
      $error("grad_mag_pipe: lane count mismatch with package");
   end

   logic [9*PIX_W-1:0] win_q;
   logic [NL-1:0]      lane_v;

   // stage 1: capture window together with its decoded lane mask
   always_ff @(posedge clk) win_q <= win_i;

   always_ff @(posedge clk) begin
      if (rst) lane_v <= '0;
      else     lane_v <= win_vld_i ? mode_to_mask(mode_i) : '0;
   end

   generate
      for (genvar k = 0; k < NL; k++) begin : g_lane
         grad_lane #(.PIX_W(PIX_W), .OP(k)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .win   (win_q),
            .vld_i (lane_v[k]),
            .mag_o (mag_o[k*MAG_W +: MAG_W]),
            .vld_o (mag_vld_o[k])
         );
      end
   endgenerate
endmodule

// File: rtl/grad_mag_chk.sv
`timescale 1ns/1ps
module grad_mag_chk #(
   parameter int PIX_W = 8,
   localparam int MAG_W = PIX_W + 3
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 win_vld_i,
   input logic [2:0]           mode_i,
   input logic [3*MAG_W-1:0]   mag_o,
   input logic [2:0]           mag_vld_o
);
   localparam int PMAX = (1 << PIX_W) - 1;
   localparam logic [MAG_W-1:0] SOB_MAX = MAG_W'(6*PMAX);
   localparam logic [MAG_W-1:0] PRE_MAX = MAG_W'(4*PMAX);
   localparam logic [MAG_W-1:0] ROB_MAX = MAG_W'(2*PMAX);

   logic [2:0] since_rst;
   always_ff @(posedge clk) begin
      if (rst)                  since_rst <= 3'd0;
      else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
   end

   wire [MAG_W-1:0] m_sob = mag_o[0 +: MAG_W];
   wire [MAG_W-1:0] m_pre = mag_o[MAG_W +: MAG_W];
   wire [MAG_W-1:0] m_rob = mag_o[2*MAG_W +: MAG_W];

   // R4, R5, R9: each lane valid follows the window and mode of four clocks earlier
   a_r4_sobel_enable: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 3'd4) |-> (mag_vld_o[0] == ($past(win_vld_i,4) &&
         ($past(mode_i,4) == 3'b001 || $past(mode_i,4) == 3'b100 ||
          $past(mode_i,4) == 3'b110 || $past(mode_i,4) == 3'b111))));
   a_r4_prewitt_enable: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 3'd4) |-> (mag_vld_o[1] == ($past(win_vld_i,4) &&
         ($past(mode_i,4) == 3'b010 || $past(mode_i,4) == 3'b100 ||
          $past(mode_i,4) == 3'b101 || $past(mode_i,4) == 3'b111))));
   a_r4_roberts_enable: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 3'd4) |-> (mag_vld_o[2] == ($past(win_vld_i,4) &&
         ($past(mode_i,4) == 3'b011 || $past(mode_i,4) == 3'b101 ||
          $past(mode_i,4) == 3'b110 || $past(mode_i,4) == 3'b111))));
   a_r6_idle_window: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 3'd4 && !$past(win_vld_i,4)) |-> (mag_vld_o == 3'b000));
   // R1: Sobel Gx+Gy is even, so |Gx|+|Gy| is even and bounded
   a_r1_sobel_even: assert property (@(posedge clk) disable iff (rst)
      mag_vld_o[0] |-> (m_sob[0] == 1'b0 && m_sob <= SOB_MAX));
   a_r2_prewitt_bound: assert property (@(posedge clk) disable iff (rst)
      mag_vld_o[1] |-> (m_pre <= PRE_MAX));
   a_r3_roberts_bound: assert property (@(posedge clk) disable iff (rst)
      mag_vld_o[2] |-> (m_rob <= ROB_MAX));
endmodule

bind grad_mag_pipe grad_mag_chk #(.PIX_W(PIX_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .win_vld_i (win_vld_i),
   .mode_i    (mode_i),
   .mag_o     (mag_o),
   .mag_vld_o (mag_vld_o)
);

// File: tb/grad_mag_pipe_bench.sv
`timescale 1ns/1ps
module grad_mag_pipe_bench;
   localparam int PIX_W = 8;
   localparam int MAG_W = PIX_W + 3;
   localparam int HMAX  = 4096;

   logic                clk = 1'b0;
   logic                rst = 1'b1;
   logic [9*PIX_W-1:0]  win_i = '0;
   logic                win_vld_i = 1'b0;
   logic [2:0]          mode_i = 3'b000;
   logic [3*MAG_W-1:0]  mag_o;
   logic [2:0]          mag_vld_o;

   int n_checks = 0;
   int n_fails  = 0;
   int cyc      = 0;

   logic [9*PIX_W-1:0] h_win  [HMAX];
   logic               h_vld  [HMAX];
   logic [2:0]         h_mode [HMAX];
   string              h_tag  [HMAX];

   always #10 clk = ~clk;

   grad_mag_pipe #(.PIX_W(PIX_W)) u_grad_mag_pipe (
      .clk       (clk),
      .rst       (rst),
      .win_i     (win_i),
      .win_vld_i (win_vld_i),
      .mode_i    (mode_i),
      .mag_o     (mag_o),
      .mag_vld_o (mag_vld_o)
   );

   function automatic int px(input logic [9*PIX_W-1:0] w, input int k);
      return int'(w[k*PIX_W +: PIX_W]);
   endfunction
   function automatic int iabs(input int v);
      return (v < 0) ? -v : v;
   endfunction
   function automatic int exp_mag(input logic [9*PIX_W-1:0] w, input int lane);
      int gx, gy;
      if (lane == 0) begin
         gx = (px(w,6) + 2*px(w,7) + px(w,8)) - (px(w,0) + 2*px(w,1) + px(w,2));
         gy = (px(w,0) + 2*px(w,3) + px(w,6)) - (px(w,2) + 2*px(w,5) + px(w,8));
      end else if (lane == 1) begin
         gx = (px(w,0) + px(w,1) + px(w,2)) - (px(w,6) + px(w,7) + px(w,8));
         gy = (px(w,2) + px(w,5) + px(w,8)) - (px(w,0) + px(w,3) + px(w,6));
      end else begin
         gx = px(w,4) - px(w,8);
         gy = px(w,5) - px(w,7);
      end
      return iabs(gx) + iabs(gy);
   endfunction
   // R4 mapping: bit0 Sobel, bit1 Prewitt, bit2 Roberts
   function automatic logic [2:0] exp_mask(input logic [2:0] m);
      case (m)
         3'b001: return 3'b001;
         3'b010: return 3'b010;
         3'b011: return 3'b100;
         3'b100: return 3'b011;
         3'b101: return 3'b110;
         3'b110: return 3'b101;
         3'b111: return 3'b111;
         default: return 3'b000;
      endcase
   endfunction

   function automatic logic [9*PIX_W-1:0] pattern(input int p);
      logic [9*PIX_W-1:0] w = '0;
      if (p == 1) w = '1;
      else if (p >= 2 && p <= 10) w[(p-2)*PIX_W +: PIX_W] = '1;
      else if (p == 11) begin  // Sobel worst corner: D3, D6, D7 full
         w[3*PIX_W +: PIX_W] = '1;
         w[6*PIX_W +: PIX_W] = '1;
         w[7*PIX_W +: PIX_W] = '1;
      end else if (p == 12) begin  // opposite corner: D1, D2, D5 full
         w[1*PIX_W +: PIX_W] = '1;
         w[2*PIX_W +: PIX_W] = '1;
         w[5*PIX_W +: PIX_W] = '1;
      end else if (p == 13) begin  // checkerboard
         for (int k = 0; k < 9; k += 2) w[k*PIX_W +: PIX_W] = '1;
      end
      return w;
   endfunction

   task automatic check_out();
      int idx;
      logic [2:0] em;
      if (cyc < 4) return;
      idx = cyc - 4;
      em = h_vld[idx] ? exp_mask(h_mode[idx]) : 3'b000;
      n_checks++;
      if (mag_vld_o !== em) begin
         n_fails++;
         $display("FAIL R4 valid mask (%s) cyc %0d: got %b exp %b", h_tag[idx], cyc, mag_vld_o, em);
      end
      for (int l = 0; l < 3; l++) begin
         if (em[l]) begin
            int e = exp_mag(h_win[idx], l);
            int g = int'(mag_o[l*MAG_W +: MAG_W]);
            n_checks++;
            if (g != e) begin
               n_fails++;
               $display("FAIL %s lane %0d (%s) cyc %0d: got %0d exp %0d",
                        (l == 0) ? "R1" : (l == 1) ? "R2" : "R3", l, h_tag[idx], cyc, g, e);
            end
         end
      end
   endtask

   task automatic step(input logic [9*PIX_W-1:0] w, input logic v,
                       input logic [2:0] m, input logic r, input string tag);
      @(negedge clk);
      check_out();
      rst = r; win_i = w; win_vld_i = v; mode_i = m;
      if (r) begin
         for (int d = 1; d <= 3; d++) if (cyc - d >= 0) h_vld[cyc-d] = 1'b0;
      end
      h_win[cyc] = w; h_vld[cyc] = v & ~r; h_mode[cyc] = m; h_tag[cyc] = tag;
      cyc++;
   endtask

   function automatic logic [9*PIX_W-1:0] rnd_win();
      logic [9*PIX_W-1:0] w;
      for (int k = 0; k < 9; k++) w[k*PIX_W +: PIX_W] = PIX_W'($urandom);
      return w;
   endfunction

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_checks++; n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin : stim
      // R7: reset state
      for (int i = 0; i < 4; i++) step(rnd_win(), 1'b1, 3'b111, 1'b1, "R7 reset");
      // R4/R8: every mode code crossed with every corner pattern, back to back
      for (int m = 0; m < 8; m++)
         for (int p = 0; p < 14; p++)
            step(pattern(p), 1'b1, 3'(m), 1'b0, "R8 corner");
      // R9: random mode on every window, occasional gaps
      for (int i = 0; i < 200; i++)
         step(rnd_win(), ($urandom % 4) != 0, 3'($urandom), 1'b0, "R9 mode per window");
      // R6: invalid windows with every mode
      for (int i = 0; i < 40; i++)
         step(rnd_win(), 1'b0, 3'(i), 1'b0, "R6 idle window");
      // R5: full-rate stream with all lanes
      for (int i = 0; i < 64; i++)
         step(rnd_win(), 1'b1, 3'b111, 1'b0, "R5 full rate");
      // R7: reset with windows in flight
      for (int i = 0; i < 2; i++) step(rnd_win(), 1'b1, 3'b111, 1'b1, "R7 mid reset");
      for (int i = 0; i < 20; i++)
         step(rnd_win(), 1'b1, 3'($urandom), 1'b0, "R5 after reset");
      for (int i = 0; i < 5; i++) step('0, 1'b0, 3'b000, 1'b0, "R6 flush");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule